// File: doc/BRIEF.md
# Hierarchical Latched Interrupt Aggregator

This block gathers event indications from eight identical ports and turns them into a three-level interrupt hierarchy for a host processor. Each port owns four groups of eight latched status bits: transmit framer, receive framer, line interface and bit-error tester. A rising edge on any event input sets its latched bit. The host clears a bit by writing a one to it. A mask register for each group decides which latched bits may propagate upward.

Above the latched bits sit two levels of real-time summaries. A per-port information register shows which of the four groups holds a pending unmasked bit. Three global registers, one each for framer, line-interface and bit-error-tester events, carry one bit per port, so the host can find the ports that need service with a single read. One registered, active-low interrupt line summarises the whole tree. Masked bits are still latched, so the host can poll them.

Top module: `intr_aggr_top`

## Requirements
- R1: A latched status bit is set on the clock edge at which its event input is high and was low in the previous cycle, whatever its mask bit holds. A level held high sets the bit only once. The event for port p, group g, bit b is `evtIn[(p*4+g)*8+b]`. Groups are 0 transmit, 1 receive, 2 line interface, 3 bit-error tester. The previous-cycle value resets to 0.
- R2: A latched bit is cleared only when the host writes 1 to that bit position of its status register. Writing 0 leaves the bit unchanged.
- R3: If an event rise and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R4: Mask bit value 1 lets its latched bit propagate and value 0 blocks it. Mask registers read back what was last written.
- R5: The per-port information register is real time. Bit g is 1 while any latched bit of group g on that port is set with its mask bit at 1. Bits 7:4 read 0.
- R6: The global registers are real time, and bit p refers to port p. In the framer register, bit p is the OR of port p's transmit and receive information bits. The line-interface and bit-error-tester registers follow group 2 and group 3 respectively.
- R7: `irqN` is registered and active low. It is 0 in the cycle after any global information bit is 1, and 1 in the cycle after none are.
- R8: Information registers are read only. Writes to them change no register.
- R9: Address map. With `addr[7]`=0, the port number is `addr[6:4]`. Offset g (0..3) of that port is group g's status register, offset 4+g is its mask, and offset 8 is the port information register. The global registers sit at 0x80 (framer), 0x81 (line interface) and 0x82 (bit-error tester). `rdData` is registered: it shows the register at `addr` one clock later. Unmapped addresses read 0.
- R10: After reset, all latched bits and masks are 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 256 | Event conditions, eight bits per group, four groups per port |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| irqN | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that `evtIn`, `wrEn`, `addr` and `wrData` change only between clock edges. They also assume that reset is held for at least one edge, so that the checker's copy of the previous event values starts at the same zero as the design's. The bench drives all inputs on the falling edge and holds reset low for several cycles. It makes event rises and host writes coincide only in the one scenario that checks that the set wins.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;
  localparam int PORTS    = 8;
  localparam int GROUPS   = 4;
  localparam int GBITS    = 8;
  localparam int ADDR_W   = 8;
  localparam int PORT_W   = $clog2(PORTS);
  localparam int GRP_W    = $clog2(GROUPS);
  localparam int EVT_W    = PORTS * GROUPS * GBITS;
  localparam int PORT_LSB = 4;
  localparam int INFO_OFS = 8;

  localparam int G_TX   = 0;
  localparam int G_RX   = 1;
  localparam int G_LINE = 2;
  localparam int G_BERT = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_MASK, RD_PINFO, RD_GFRM, RD_GLINE, RD_GBERT
  } rd_kind_e;

  typedef struct packed {
    logic              statusWr;
    logic              maskWr;
    logic [PORT_W-1:0] port;
    logic [GRP_W-1:0]  grp;
    logic [GBITS-1:0]  data;
    rd_kind_e          rdKind;
  } strobe_t;
endpackage

// File: rtl/intr_aggr_ctrl.sv
module intr_aggr_ctrl
  import intr_aggr_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GBITS-1:0]  wrData,
  output strobe_t           stb
);
  logic       isGlobal;
  logic [3:0] ofs;

  assign isGlobal = addr[ADDR_W-1];
  assign ofs      = addr[3:0];

  always_comb begin
    stb          = '0;
    stb.port     = addr[PORT_LSB +: PORT_W];
    stb.grp      = ofs[GRP_W-1:0];
    stb.data     = wrData;
    stb.rdKind   = RD_NONE;
    if (isGlobal) begin
      unique case (addr[ADDR_W-2:0])
        7'd0:    stb.rdKind = RD_GFRM;
        7'd1:    stb.rdKind = RD_GLINE;
        7'd2:    stb.rdKind = RD_GBERT;
        default: stb.rdKind = RD_NONE;
      endcase
    end else begin
      if (ofs < 4'(GROUPS)) begin
        stb.rdKind   = RD_STATUS;
        stb.statusWr = wrEn;
      end else if (ofs < 4'(2 * GROUPS)) begin
        stb.rdKind   = RD_MASK;
        stb.maskWr   = wrEn;
      end else if (ofs == 4'(INFO_OFS)) begin
        stb.rdKind   = RD_PINFO;
      end
    end
  end
endmodule

// File: rtl/intr_aggr_datapath.sv
module intr_aggr_datapath
  import intr_aggr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtIn,
  input  strobe_t          stb,
  output logic [GBITS-1:0] rdData,
  output logic             irqN
);
  logic [EVT_W-1:0]  evtPrev;
  logic [EVT_W-1:0]  latchQ;
  logic [EVT_W-1:0]  maskQ;
  logic [GROUPS-1:0] pend [PORTS];
  logic [PORTS-1:0]  gFrm, gLine, gBert;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int BASE = (p * GROUPS + g) * GBITS;
      logic             hit;
      logic [GBITS-1:0] clrBits, riseBits;

      assign hit      = (stb.port == PORT_W'(p)) && (stb.grp == GRP_W'(g));
      assign clrBits  = (stb.statusWr && hit) ? stb.data : '0;
      assign riseBits = evtIn[BASE +: GBITS] & ~evtPrev[BASE +: GBITS];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          evtPrev[BASE +: GBITS] <= '0;
          latchQ[BASE +: GBITS]  <= '0;
          maskQ[BASE +: GBITS]   <= '0;
        end else begin
          evtPrev[BASE +: GBITS] <= evtIn[BASE +: GBITS];
          latchQ[BASE +: GBITS]  <= (latchQ[BASE +: GBITS] & ~clrBits) | riseBits;
          if (stb.maskWr && hit) maskQ[BASE +: GBITS] <= stb.data;
        end
      end

      assign pend[p][g] = |(latchQ[BASE +: GBITS] & maskQ[BASE +: GBITS]);
    end

    assign gFrm[p]  = pend[p][G_TX] | pend[p][G_RX];
    assign gLine[p] = pend[p][G_LINE];
    assign gBert[p] = pend[p][G_BERT];
  end

  logic [GBITS-1:0] rdNext;
  logic [$clog2(EVT_W)-1:0] sliceBase;
  assign sliceBase = ($clog2(EVT_W))'((int'(stb.port) * GROUPS + int'(stb.grp)) * GBITS);

  always_comb begin
    rdNext = '0;
    unique case (stb.rdKind)
      RD_STATUS: rdNext = latchQ[sliceBase +: GBITS];
      RD_MASK:   rdNext = maskQ[sliceBase +: GBITS];
      RD_PINFO:  rdNext = GBITS'(pend[stb.port]);
      RD_GFRM:   rdNext = GBITS'(gFrm);
      RD_GLINE:  rdNext = GBITS'(gLine);
      RD_GBERT:  rdNext = GBITS'(gBert);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irqN   <= 1'b1;
    end else begin
      rdData <= rdNext;
      irqN   <= ~(|{gFrm, gLine, gBert});
    end
  end
endmodule

// File: rtl/intr_aggr_top.sv
module intr_aggr_top
  import intr_aggr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GBITS-1:0]  wrData,
  output logic [GBITS-1:0]  rdData,
  output logic              irqN
);
  strobe_t stb;

  intr_aggr_ctrl ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .stb    (stb)
  );

  intr_aggr_datapath dp (
    .clk    (clk),
    .rstN   (rstN),
    .evtIn  (evtIn),
    .stb    (stb),
    .rdData (rdData),
    .irqN   (irqN)
  );
endmodule

// File: rtl/intr_aggr_chk.sv
module intr_aggr_chk
  import intr_aggr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [EVT_W-1:0]  evtIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [EVT_W-1:0]  latchQ,
  input logic [EVT_W-1:0]  maskQ,
  input logic              irqN
);
  logic [EVT_W-1:0] prevC;
  always_ff @(posedge clk) begin
    if (!rstN) prevC <= '0;
    else       prevC <= evtIn;
  end

  logic [EVT_W-1:0] riseC;
  logic             statusWrC, infoWrC;
  assign riseC     = evtIn & ~prevC;
  assign statusWrC = wrEn && !addr[ADDR_W-1] && (addr[3:0] < 4'(GROUPS));
  assign infoWrC   = wrEn && (addr[ADDR_W-1] || addr[3:0] == 4'(INFO_OFS));

  // R1: every rising event is latched on the next edge
  p_rise_latched_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & $past(riseC)) == $past(riseC)));

  // R2: without a status write no latched bit falls
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !statusWrC |=> ((latchQ & $past(latchQ)) == $past(latchQ)));

  // R7: interrupt line follows pending unmasked bits one cycle later
  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == !$past(|(latchQ & maskQ))));

  // R8: writes to information registers leave masks and latches alone
  p_info_ro_r8: assert property (@(posedge clk) disable iff (!rstN)
    infoWrC |=> ($stable(maskQ) && ((latchQ & $past(latchQ)) == $past(latchQ))));
endmodule

bind intr_aggr_top intr_aggr_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .evtIn  (evtIn),
  .wrEn   (wrEn),
  .addr   (addr),
  .latchQ (dp.latchQ),
  .maskQ  (dp.maskQ),
  .irqN   (irqN)
);

// File: tb/intr_aggr_top_test.sv
module intr_aggr_top_test;
  import intr_aggr_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [EVT_W-1:0]  evtIn = '0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [GBITS-1:0]  wrData = '0;
  logic [GBITS-1:0]  rdData;
  logic              irqN;
  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  intr_aggr_top uut (.*);

  function automatic void check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  function automatic int evIdx(int p, int g, int b);
    return (p * GROUPS + g) * GBITS + b;
  endfunction

  function automatic logic [7:0] regAddr(int p, int ofs);
    return 8'((p << 4) | ofs);
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; wrEn = 1'b0; tick(); d = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1; tick(); wrEn = 1'b0;
  endtask

  task automatic pulse(int idx);
    evtIn[idx] = 1'b1; tick(); evtIn[idx] = 1'b0; tick();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 irqN", {7'd0, irqN}, 8'h01);
    rd(regAddr(3, 1), d); check("R10 status", d, 8'h00);
    rd(regAddr(3, 5), d); check("R10 mask", d, 8'h00);
    rd(8'h80, d);         check("R10 global", d, 8'h00);
    rd(8'h8F, d);         check("R9 unmapped", d, 8'h00);
  endtask

  task automatic t_masked_latch();
    logic [7:0] d;
    pulse(evIdx(2, G_TX, 3)); tick();
    rd(regAddr(2, 0), d); check("R1 latch while masked", d, 8'h08);
    check("R4 masked no irq", {7'd0, irqN}, 8'h01);
    rd(8'h80, d); check("R4 masked global", d, 8'h00);
  endtask

  task automatic t_unmask();
    logic [7:0] d;
    wr(regAddr(2, 4), 8'h08);
    rd(regAddr(2, 4), d); check("R4 mask readback", d, 8'h08);
    rd(regAddr(2, 8), d); check("R5 port info tx", d, 8'h01);
    rd(8'h80, d); check("R6 framer global", d, 8'h04);
    check("R7 irq asserted", {7'd0, irqN}, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(regAddr(2, 0), 8'hF7);
    rd(regAddr(2, 0), d); check("R2 zero write keeps", d, 8'h08);
    wr(regAddr(2, 0), 8'h08);
    check("R7 irq one cycle late", {7'd0, irqN}, 8'h00);
    tick();
    check("R7 irq released", {7'd0, irqN}, 8'h01);
    rd(regAddr(2, 0), d); check("R2 cleared", d, 8'h00);
    rd(8'h80, d); check("R6 framer cleared", d, 8'h00);
  endtask

  task automatic t_level_once();
    logic [7:0] d;
    evtIn[evIdx(4, G_RX, 0)] = 1'b1; tick(); tick();
    wr(regAddr(4, 1), 8'h01); tick(); tick();
    rd(regAddr(4, 1), d); check("R1 level latches once", d, 8'h00);
    evtIn[evIdx(4, G_RX, 0)] = 1'b0; tick();
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse(evIdx(6, G_TX, 5));
    addr = regAddr(6, 0); wrData = 8'h20; wrEn = 1'b1;
    evtIn[evIdx(6, G_TX, 5)] = 1'b1; tick();
    wrEn = 1'b0; evtIn[evIdx(6, G_TX, 5)] = 1'b0;
    rd(regAddr(6, 0), d); check("R3 set wins", d, 8'h20);
    wr(regAddr(6, 0), 8'h20);
  endtask

  task automatic t_categories();
    logic [7:0] d;
    wr(regAddr(5, 6), 8'hFF); wr(regAddr(7, 7), 8'h80); wr(regAddr(0, 5), 8'h02);
    pulse(evIdx(5, G_LINE, 6)); pulse(evIdx(7, G_BERT, 7)); pulse(evIdx(0, G_RX, 1));
    rd(8'h81, d); check("R6 line global", d, 8'h20);
    rd(8'h82, d); check("R6 bert global", d, 8'h80);
    rd(8'h80, d); check("R6 framer rx", d, 8'h01);
    rd(regAddr(0, 8), d); check("R5 port info rx", d, 8'h02);
    rd(regAddr(7, 8), d); check("R5 port info bert", d, 8'h08);
    wr(8'h81, 8'hFF); wr(regAddr(7, 8), 8'h00);
    rd(8'h81, d); check("R8 global write ignored", d, 8'h20);
    rd(regAddr(7, 7), d); check("R8 mask untouched", d, 8'h80);
    rd(regAddr(7, 8), d); check("R8 info write ignored", d, 8'h08);
  endtask

  initial begin
    repeat (4) tick();
    rstN = 1'b1; tick();
    t_reset();
    t_masked_latch();
    t_unmask();
    t_w1c();
    t_level_once();
    t_set_wins();
    t_categories();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule